// File: doc/BRIEF.md
# Windowed Sample-Memory Access Arbiter

This block sits between a Wishbone slave port and a dual-port sample memory. A sample producer writes on one port; the host reads on the other. The host never sees the whole store. It sees only a movable window of 2048 sixteen-bit words, which is 4096 bytes. A pointer register sets the window's base word. The host can load the pointer directly. It can also set the pointer to step forward by one word after every successful window read, so a long record can be streamed through one fixed bus offset.

Host reads of the window are served only while the acquisition engine reports idle. A read attempted while the engine is busy gets an error response. That read returns zero, touches no memory and leaves the pointer where it was. Sample writes take a valid/ready stream whose ready is held high at all times. The producer is therefore never back-pressured, whatever the bus is doing. A synchronous dual-port memory model stands in for the external memory controller.

The window is `WIN_W` = 2^`WIN_AW` words and the store is 2^`MEM_AW` words. The defaults are 2048 and 4096. The production store of 32M words uses `MEM_AW` = 25.

Top module: `sample_window_arbiter`

## Requirements
- R1: After reset the pointer is 0, auto-step is off, and `wb_ack` and `wb_err` are low.
- R2: When `wb_adr[WIN_AW]` is 0, a read returns the word at physical address (pointer + `wb_adr[WIN_AW-1:0]`) mod 2^`MEM_AW`. The word appears in `wb_dat_r[15:0]` and the upper bits are zero. `wb_ack` is high in the cycle after the request is accepted.
- R3: When `wb_adr[WIN_AW]` is 1, the control word is addressed, whatever the lower address bits are. Its bits [`MEM_AW`-1:0] hold the pointer, bit 30 holds auto-step and bit 31 holds the live idle input. A write loads the pointer and auto-step and ignores bit 31. Both reads and writes are acknowledged with `wb_ack`.
- R4: With auto-step on, each acknowledged window read adds 1 to the pointer. The pointer wraps from 2^`MEM_AW`-1 to 0. The read itself uses the value the pointer had before the step.
- R5: With auto-step off, window reads leave the pointer unchanged.
- R6: A window read made while `acq_idle` is low is answered with `wb_err` and returns zero. It does not advance the pointer.
- R7: A write to the window region is answered with `wb_err` and leaves the memory unchanged.
- R8: `smp_ready` is always high. Every cycle in which `smp_valid` is high stores `smp_data` at `smp_addr`, whatever bus traffic is in progress.
- R9: Each accepted request gets exactly one response, `wb_ack` or `wb_err` and never both. If strobe is still high on the edge where the response is given, that does not start a second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_idle | input | 1 | High while acquisition is idle |
| smp_valid | input | 1 | Sample write valid |
| smp_ready | output | 1 | Sample write ready, always 1 |
| smp_addr | input | MEM_AW | Sample word address |
| smp_data | input | DATA_W | Sample value |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | WIN_AW+1 | Word address; top bit selects the control word |
| wb_dat_w | input | 32 | Bus write data |
| wb_dat_r | output | 32 | Bus read data |
| wb_ack | output | 1 | Normal response |
| wb_err | output | 1 | Error response |

## Verification
A small build is used: a 64-word store and an 8-word window. The bench fills the store with an arithmetic pattern. It then reads every window offset from every pointer value. These reads separate correct base-plus-offset addressing and wrap-around from truncated or swapped address paths. An auto-step run starts near the top of the store and crosses the wrap point. It shows whether the step happens after the read and wraps correctly. Busy-state reads, window writes and sample writes made during bus traffic show whether the gating is exact and whether the error path has no side effects.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int BUS_DW   = 32;
  localparam int AUTO_BIT = 30;
  localparam int IDLE_BIT = 31;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_MEM  = 2'd1,
    RSP_CSR  = 2'd2,
    RSP_ZERO = 2'd3
  } rsp_e;
endpackage

// File: rtl/sw_dpram.sv
module sw_dpram #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)); // R8
endmodule

// File: rtl/sw_window_ptr.sv
module sw_window_ptr #(
  parameter int MEM_AW = 12,
  parameter int WIN_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [MEM_AW-1:0] ld_ptr,
  input  logic              ld_auto,
  input  logic              rd_done,
  input  logic [WIN_AW-1:0] offset,
  output logic [MEM_AW-1:0] ptr,
  output logic              auto_en,
  output logic [MEM_AW-1:0] phys_addr
);
  logic [MEM_AW-1:0] ptr_q;
  logic              auto_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      auto_q <= 1'b0;
    end else if (ld) begin
      ptr_q  <= ld_ptr;
      auto_q <= ld_auto;
    end else if (rd_done && auto_q) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr       = ptr_q;
  assign auto_en   = auto_q;
  assign phys_addr = ptr_q + MEM_AW'(offset);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && auto_q && !ld) |=> ptr_q == MEM_AW'($past(ptr_q) + 1'b1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !auto_q && !ld) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/sw_bus_ctrl.sv
module sw_bus_ctrl
  import sw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc,
  input  logic stb,
  input  logic we,
  input  logic csr_sel,
  input  logic acq_idle,
  output logic rd_go,
  output logic csr_ld,
  output logic ack,
  output logic err,
  output rsp_e rsp
);
  logic ack_q, err_q;
  rsp_e rsp_q;
  logic accept;

  assign accept = cyc && stb && !ack_q && !err_q;
  assign rd_go  = accept && !csr_sel && !we && acq_idle;
  assign csr_ld = accept && csr_sel && we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      rsp_q <= RSP_NONE;
    end else if (accept) begin
      if (csr_sel) begin
        ack_q <= 1'b1;
        err_q <= 1'b0;
        rsp_q <= we ? RSP_ZERO : RSP_CSR;
      end else if (!we && acq_idle) begin
        ack_q <= 1'b1;
        err_q <= 1'b0;
        rsp_q <= RSP_MEM;
      end else begin
        ack_q <= 1'b0;
        err_q <= 1'b1;
        rsp_q <= RSP_ZERO;
      end
    end else begin
      ack_q <= 1'b0;
      err_q <= 1'b0;
      rsp_q <= RSP_NONE;
    end
  end

  assign ack = ack_q;
  assign err = err_q;
  assign rsp = rsp_q;

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_q && err_q)); // R9
  AST_SINGLE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q || err_q) |=> !(ack_q || err_q)); // R9
  AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack_q && !err_q && !csr_sel && !we && !acq_idle) |=> err_q); // R6
  AST_WIN_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && stb && !ack_q && !err_q && !csr_sel && we) |=> err_q); // R7
endmodule

// File: rtl/sample_window_arbiter.sv
module sample_window_arbiter
  import sw_pkg::*;
#(
  parameter int MEM_AW = 12,
  parameter int WIN_AW = 11,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acq_idle,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [MEM_AW-1:0]   smp_addr,
  input  logic [DATA_W-1:0]   smp_data,
  input  logic                wb_cyc,
  input  logic                wb_stb,
  input  logic                wb_we,
  input  logic [WIN_AW:0]     wb_adr,
  input  logic [BUS_DW-1:0]   wb_dat_w,
  output logic [BUS_DW-1:0]   wb_dat_r,
  output logic                wb_ack,
  output logic                wb_err
);
  localparam int PAD_W = BUS_DW - DATA_W;

  logic              rd_go, csr_ld;
  rsp_e              rsp;
  logic [MEM_AW-1:0] ptr, phys_addr;
  logic              auto_en;
  logic [DATA_W-1:0] mem_q;
  logic [BUS_DW-1:0] csr_word;
  logic              dat_w_unused;

  assign smp_ready    = 1'b1;
  assign dat_w_unused = ^{wb_dat_w[IDLE_BIT], wb_dat_w[AUTO_BIT-1:MEM_AW]};

  sw_bus_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (wb_cyc),
    .stb      (wb_stb),
    .we       (wb_we),
    .csr_sel  (wb_adr[WIN_AW]),
    .acq_idle (acq_idle),
    .rd_go    (rd_go),
    .csr_ld   (csr_ld),
    .ack      (wb_ack),
    .err      (wb_err),
    .rsp      (rsp)
  );

  sw_window_ptr #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (csr_ld),
    .ld_ptr    (wb_dat_w[MEM_AW-1:0]),
    .ld_auto   (wb_dat_w[AUTO_BIT]),
    .rd_done   (rd_go),
    .offset    (wb_adr[WIN_AW-1:0]),
    .ptr       (ptr),
    .auto_en   (auto_en),
    .phys_addr (phys_addr)
  );

  sw_dpram #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (smp_valid),
    .waddr (smp_addr),
    .wdata (smp_data),
    .re    (rd_go),
    .raddr (phys_addr),
    .rdata (mem_q)
  );

  always_comb begin
    csr_word               = '0;
    csr_word[MEM_AW-1:0]   = ptr;
    csr_word[AUTO_BIT]     = auto_en;
    csr_word[IDLE_BIT]     = acq_idle;
  end

  always_comb begin
    case (rsp)
      RSP_MEM: wb_dat_r = {{PAD_W{1'b0}}, mem_q};
      RSP_CSR: wb_dat_r = csr_word;
      default: wb_dat_r = '0;
    endcase
  end

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_err |-> wb_dat_r == '0); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !wb_ack && !wb_err); // R1
endmodule

// File: tb/sample_window_arbiter_bench.sv
module sample_window_arbiter_bench;
  localparam int MAW = 6;
  localparam int WAW = 3;
  localparam int DEPTH = 1 << MAW;
  localparam int WIN = 1 << WAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_idle = 1'b1;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [MAW-1:0] smp_addr = '0;
  logic [15:0] smp_data = '0;
  logic wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [WAW:0] wb_adr = '0;
  logic [31:0] wb_dat_w = '0;
  logic [31:0] wb_dat_r;
  logic wb_ack, wb_err;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [DEPTH];

  always #10 clk = ~clk;

  sample_window_arbiter #(.MEM_AW(MAW), .WIN_AW(WAW), .DATA_W(16)) u_sample_window_arbiter (
    .clk(clk), .rst_n(rst_n), .acq_idle(acq_idle),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_addr(smp_addr), .smp_data(smp_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack), .wb_err(wb_err)
  );

  function automatic logic [15:0] pat(input int a, input int salt);
    int v;
    v = a * 40503 + salt * 977 + 7;
    return v[15:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [WAW:0] adr, input logic [31:0] dw,
                     output logic [31:0] dr, output logic ak, output logic er, output int lat);
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = adr; wb_dat_w = dw;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wb_ack && !wb_err && lat < 20);
    dr = wb_dat_r; ak = wb_ack; er = wb_err;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
  endtask

  task automatic smp_write(input int a, input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_addr = MAW'(a); smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
    model[a] = d;
  endtask

  function automatic logic [31:0] csr_exp(input int p, input logic au, input logic idl);
    logic [31:0] w;
    w = '0;
    w[MAW-1:0] = MAW'(p);
    w[30] = au;
    w[31] = idl;
    return w;
  endfunction

  localparam logic [WAW:0] CSR = {1'b1, {WAW{1'b0}}};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dr;
    logic ak, er;
    int lat, p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack/err after reset", {30'b0, wb_ack, wb_err}, 32'd0);
    bus(1'b0, CSR, 0, dr, ak, er, lat);
    check("R1 csr after reset", dr, csr_exp(0, 1'b0, 1'b1));
    check("R8 ready", {31'b0, smp_ready}, 32'd1);

    for (int a = 0; a < DEPTH; a++) smp_write(a, pat(a, 0));

    // R2 exhaustive pointer x offset sweep
    for (int q = 0; q < DEPTH; q++) begin
      bus(1'b1, CSR, csr_exp(q, 1'b0, 1'b0), dr, ak, er, lat);
      for (int o = 0; o < WIN; o++) begin
        bus(1'b0, (WAW+1)'(o), 0, dr, ak, er, lat);
        check("R2 window read", dr, {16'b0, model[(q + o) % DEPTH]});
        check("R2 ack latency", {ak, er, 30'(lat)}, {2'b10, 30'd1});
      end
      bus(1'b0, (WAW+1)'(WIN + (q % WIN)), 0, dr, ak, er, lat);
      check("R5 R3 csr alias and hold", dr, csr_exp(q, 1'b0, 1'b1));
    end

    // R4 auto-step across wrap
    p = DEPTH - 4;
    bus(1'b1, CSR, csr_exp(p, 1'b1, 1'b0) | 32'h8000_0000, dr, ak, er, lat);
    check("R3 write ack", {31'b0, ak}, 32'd1);
    for (int k = 0; k < 10; k++) begin
      bus(1'b0, (WAW+1)'(2), 0, dr, ak, er, lat);
      check("R4 auto read", dr, {16'b0, model[(p + 2) % DEPTH]});
      p = (p + 1) % DEPTH;
    end
    bus(1'b0, CSR, 0, dr, ak, er, lat);
    check("R4 pointer after wrap", dr, csr_exp(p, 1'b1, 1'b1));

    // R6 busy read
    acq_idle = 1'b0;
    bus(1'b0, CSR, 0, dr, ak, er, lat);
    check("R3 idle flag low", dr, csr_exp(p, 1'b1, 1'b0));
    for (int o = 0; o < WIN; o++) begin
      bus(1'b0, (WAW+1)'(o), 0, dr, ak, er, lat);
      check("R6 busy err", {ak, er, dr[29:0]}, 32'h4000_0000);
      check("R6 busy data", dr, 32'd0);
    end
    bus(1'b0, CSR, 0, dr, ak, er, lat);
    check("R6 no advance", dr, csr_exp(p, 1'b1, 1'b0));

    // R8 sample write concurrent with bus activity
    fork
      smp_write(5, 16'hBEEF);
      bus(1'b0, CSR, 0, dr, ak, er, lat);
    join
    acq_idle = 1'b1;
    bus(1'b1, CSR, csr_exp(5, 1'b0, 1'b0), dr, ak, er, lat);

    // R7 window write ignored
    bus(1'b1, (WAW+1)'(0), 32'h0000_1234, dr, ak, er, lat);
    check("R7 write err", {30'b0, ak, er}, 32'd1);
    bus(1'b0, (WAW+1)'(0), 0, dr, ak, er, lat);
    check("R7 R8 memory value", dr, 32'h0000_BEEF);

    // R9 strobe held through response edge
    @(negedge clk);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = 1'b0; wb_adr = (WAW+1)'(1);
    @(negedge clk);
    check("R9 first response", {30'b0, wb_ack, wb_err}, 32'd2);
    @(negedge clk);
    check("R9 no back-to-back", {30'b0, wb_ack, wb_err}, 32'd0);
    wb_cyc = 1'b0; wb_stb = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule